// File: doc/BRIEF.md
# Pseudo-Static Memory Refresh Engine

This block is the on-die refresh logic of a pseudo-static memory. It keeps a refresh row counter, times each refresh and recovery with a shared phase timer, and steers the row address multiplexer between the externally supplied row and the refresh counter. Every refresh and every accepted external access produces a one-cycle row-activate strobe. The memory array and sense amplifiers are outside this block.

A shared active-low pin, `oe_ref_n`, acts as an output enable while the chip is selected and as a refresh request while both chip enables are inactive (high). A short low pulse on that pin runs one auto-refresh. Holding the pin low for `SELF_ENTRY_CYC` cycles moves the engine into self-refresh, where the internal timer starts a refresh every `SELF_INTERVAL_CYC` cycles until the pin returns high. The default parameter values assume a 200 MHz oscillator. A refresh then takes 160 ns, self-refresh begins after 8 µs low, and the default interval refreshes all 512 rows in 6.4 ms, inside the 8 ms budget. A recovery delay follows every refresh episode. While `busy` is high, an external access is held off and is accepted only after the delay has passed.

The controller runs as a state machine with six states:
- `ST_IDLE` waits for requests.
- `ST_ROW` is a refresh in progress.
- `ST_HOLD` covers the time after an auto-refresh while the pin is still low but not yet long enough for self-refresh.
- `ST_SELF` is the wait between self-refreshes.
- `ST_RECOVER` is the recovery delay.
- `ST_ACCESS` is an external access that lasts while the chip stays selected.

Its transitions are:
- IDLE→ACCESS when selected.
- IDLE→ROW when deselected with the pin low.
- ROW→RECOVER when the pin is high at the end of the refresh.
- ROW→HOLD when the pin is low and the low time is short.
- ROW→SELF when the pin is low and the low time has reached the entry count.
- HOLD→SELF when the low time reaches `SELF_ENTRY_CYC`.
- HOLD→RECOVER when the pin rises.
- SELF→ROW when the interval expires.
- SELF→RECOVER when the pin rises.
- RECOVER→IDLE after `RECOVERY_CYC` cycles.
- ACCESS→IDLE on deselect.

Top module: `psram_refresh_engine`

## Requirements
- R1: After reset, `row_act`, `rfsh_sel` and `busy` are 0, and the first refresh uses row 0.
- R2: With both `chip_en0_n` and `chip_en1_n` high, a low on `oe_ref_n` sampled at a clock edge starts a refresh. From that edge, `row_act` is 1 for one cycle, `rfsh_sel` is 1, `row_addr` equals the refresh row, and `busy` is 1.
- R3: The refresh row counter advances by one after each completed refresh and wraps from `ROWS-1` (511) to 0.
- R4: A low on `oe_ref_n` while either chip enable is low (the chip is selected) starts no refresh and leaves the refresh row unchanged.
- R5: For an auto-refresh whose pulse ends before the refresh finishes, `busy` stays high for exactly `REFRESH_CYC + RECOVERY_CYC` cycles.
- R6: A low on `oe_ref_n` held for fewer than `SELF_ENTRY_CYC` cycles produces exactly one refresh strobe.
- R7: A low held past `SELF_ENTRY_CYC` cycles enters self-refresh, and successive self-refresh strobes are exactly `SELF_INTERVAL_CYC` cycles apart.
- R8: When `oe_ref_n` rises during the self-refresh wait, `busy` stays high for exactly `RECOVERY_CYC` more cycles.
- R9: Selecting the chip while idle gives one `row_act` strobe on the next edge, with `rfsh_sel` 0, `busy` 0, and `row_addr` equal to the `ext_row` sampled at that edge.
- R10: A selection that arrives while `busy` is high is not strobed until `busy` is low. It is then accepted with its external row.
- R11: `row_act` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en0_n | input | 1 | First chip enable, active low |
| chip_en1_n | input | 1 | Second chip enable, active low |
| oe_ref_n | input | 1 | Output enable while selected, refresh request while deselected, active low |
| ext_row | input | ROW_W | External row address |
| row_addr | output | ROW_W | Selected row address to the row decoder |
| row_act | output | 1 | One-cycle row-activate strobe |
| rfsh_sel | output | 1 | 1 while the multiplexer selects the refresh counter |
| busy | output | 1 | High from refresh start until recovery ends |

## Verification
Every output is registered from the next state, so the strobe, mux select and busy all change on the same edge that samples a request. They are due one cycle after the stimulus is applied. The bench drives inputs on the falling edge and samples on the next falling edge, one edge later.

The `busy` length is measured by counting falling edges while it stays high, and the count is compared with `REFRESH_CYC + RECOVERY_CYC`, or with `RECOVERY_CYC` alone after a self-refresh exit. Self-refresh spacing is taken from the cycle stamps the monitor records at each strobe.

The scoreboard expects strobes in order, each with its kind and row. The bench computes the refresh rows itself through a full wrap of the counter.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_HOLD,
        ST_SELF,
        ST_RECOVER,
        ST_ACCESS
    } rfe_state_e;
endpackage

// File: rtl/rfe_cycle_ctr.sv
module rfe_cycle_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    // saturating up-counter, synchronous clear has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en && (q != {W{1'b1}}))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/rfe_row_ctr.sv
module rfe_row_ctr #(
    parameter int ROWS  = 512,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            row <= '0;
        else if (step)
            row <= (row == LAST) ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/psram_refresh_engine.sv
module psram_refresh_engine
    import rfe_pkg::*;
#(
    parameter int ROWS              = 512,
    parameter int REFRESH_CYC       = 32,
    parameter int RECOVERY_CYC      = 6,
    parameter int SELF_ENTRY_CYC    = 1600,
    parameter int SELF_INTERVAL_CYC = 2500,
    parameter int ROW_W             = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en0_n,
    input  logic             chip_en1_n,
    input  logic             oe_ref_n,
    input  logic [ROW_W-1:0] ext_row,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_act,
    output logic             rfsh_sel,
    output logic             busy
);
    localparam int PH_MAX  = (SELF_INTERVAL_CYC > REFRESH_CYC + RECOVERY_CYC)
                             ? SELF_INTERVAL_CYC : REFRESH_CYC + RECOVERY_CYC;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int LOW_W   = $clog2(SELF_ENTRY_CYC + 1);
    localparam logic [PH_W-1:0]  ROW_END  = PH_W'(REFRESH_CYC - 1);
    localparam logic [PH_W-1:0]  REC_END  = PH_W'(RECOVERY_CYC - 1);
    localparam logic [PH_W-1:0]  WAIT_END = PH_W'(SELF_INTERVAL_CYC - REFRESH_CYC - 1);
    localparam logic [LOW_W-1:0] LOW_LIM  = LOW_W'(SELF_ENTRY_CYC - 1);

    rfe_state_e       state, nxt;
    logic [PH_W-1:0]  ph;
    logic [LOW_W-1:0] low_cnt;
    logic [ROW_W-1:0] rcnt;
    logic             desel, req_lo, low_ok, step;

    assign desel  = chip_en0_n && chip_en1_n;
    assign req_lo = !oe_ref_n;
    assign low_ok = low_cnt >= LOW_LIM;
    assign step   = (state == ST_ROW) && (nxt != ST_ROW);

    // phase timer: restarts on every state change
    rfe_cycle_ctr #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != nxt),
        .en    (1'b1),
        .q     (ph)
    );

    // low-time counter: length of the current low on the shared pin
    rfe_cycle_ctr #(.W(LOW_W)) u_lowtime (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!req_lo),
        .en    (1'b1),
        .q     (low_cnt)
    );

    rfe_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .row   (rcnt)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!desel)
                    nxt = ST_ACCESS;
                else if (req_lo)
                    nxt = ST_ROW;
            end
            ST_ROW: begin
                if (ph == ROW_END) begin
                    if (!req_lo)
                        nxt = ST_RECOVER;
                    else if (low_ok)
                        nxt = ST_SELF;
                    else
                        nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!req_lo)
                    nxt = ST_RECOVER;
                else if (low_ok)
                    nxt = ST_SELF;
            end
            ST_SELF: begin
                if (!req_lo)
                    nxt = ST_RECOVER;
                else if (ph == WAIT_END)
                    nxt = ST_ROW;
            end
            ST_RECOVER: begin
                if (ph == REC_END)
                    nxt = ST_IDLE;
            end
            ST_ACCESS: begin
                if (desel)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_addr <= '0;
            row_act  <= 1'b0;
            rfsh_sel <= 1'b0;
            busy     <= 1'b0;
        end else begin
            row_act  <= (nxt != state) && (nxt == ST_ROW || nxt == ST_ACCESS);
            rfsh_sel <= (nxt == ST_ROW);
            busy     <= (nxt == ST_ROW) || (nxt == ST_HOLD) ||
                        (nxt == ST_SELF) || (nxt == ST_RECOVER);
            if (nxt == ST_ROW && state != ST_ROW)
                row_addr <= rcnt;
            else if (nxt == ST_ACCESS && state != ST_ACCESS)
                row_addr <= ext_row;
        end
    end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int ROWS  = 512,
    parameter int ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en0_n,
    input logic             chip_en1_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             row_act,
    input logic             rfsh_sel,
    input logic             busy,
    input logic [ROW_W-1:0] rcnt
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    assert_act_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        row_act |=> !row_act);

    assert_refresh_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && rfsh_sel) |-> $past(chip_en0_n && chip_en1_n));

    assert_busy_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_sel |-> busy);

    assert_mux_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_sel |-> (row_addr == rcnt));

    assert_access_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act && !rfsh_sel) |-> !$past(busy));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rcnt != $past(rcnt)) |->
        (rcnt == (($past(rcnt) == LAST) ? '0 : $past(rcnt) + 1'b1)));
endmodule

bind psram_refresh_engine rfe_checker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rfe_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en0_n (chip_en0_n),
    .chip_en1_n (chip_en1_n),
    .row_addr   (row_addr),
    .row_act    (row_act),
    .rfsh_sel   (rfsh_sel),
    .busy       (busy),
    .rcnt       (rcnt)
);

// File: tb/psram_refresh_engine_bench.sv
module psram_refresh_engine_bench;
    localparam int ROWS  = 512;
    localparam int ROW_W = 9;
    localparam int RC    = 32;
    localparam int RV    = 6;
    localparam int SE    = 1600;
    localparam int SI    = 2500;

    typedef struct packed {
        logic             sel;
        logic [ROW_W-1:0] row;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en0_n = 1'b1, en1_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0] ext_row = '0;
    logic [ROW_W-1:0] row_addr;
    logic             row_act, rfsh_sel, busy;

    int   n_cmp = 0, n_bad = 0, cyc = 0, strobes = 0, exp_row = 0;
    exp_t sb[$];
    int   stamps[$];
    bit   prev_act = 1'b0;
    bit   done = 1'b0;

    psram_refresh_engine #(
        .ROWS(ROWS), .REFRESH_CYC(RC), .RECOVERY_CYC(RV),
        .SELF_ENTRY_CYC(SE), .SELF_INTERVAL_CYC(SI)
    ) u_psram_refresh_engine (
        .clk(clk), .rst_n(rst_n), .chip_en0_n(en0_n), .chip_en1_n(en1_n),
        .oe_ref_n(oe_n), .ext_row(ext_row), .row_addr(row_addr),
        .row_act(row_act), .rfsh_sel(rfsh_sel), .busy(busy)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops scoreboard entries as strobes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (row_act) begin
                strobes++;
                stamps.push_back(cyc);
                if (sb.size() == 0) begin
                    check(1'b0, "R2/R4 unexpected strobe row", int'(row_addr), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rfsh_sel == e.sel, "R2/R9 strobe kind", int'(rfsh_sel), int'(e.sel));
                    check(row_addr == e.row, "R2/R3/R9 strobe row", int'(row_addr), int'(e.row));
                end
                check(!prev_act, "R11 single-cycle strobe", int'(prev_act), 0);
            end
            prev_act = row_act;
        end
    end

    initial begin
        @(posedge clk);
        while (cyc < 190000 && !done) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 190000);
            finish_run();
        end
    end

    function automatic exp_t next_ref();
        exp_t e;
        e.sel = 1'b1;
        e.row = ROW_W'(exp_row);
        exp_row = (exp_row + 1) % ROWS;
        return e;
    endfunction

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // auto-refresh pulse of len edges
    task automatic auto_pulse(input int len);
        sb.push_back(next_ref());
        oe_n = 1'b0;
        repeat (len) @(negedge clk);
        oe_n = 1'b1;
        wait_idle();
        @(negedge clk);
    endtask

    initial begin
        int n, s0, t0;
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(row_act == 1'b0, "R1 reset row_act", int'(row_act), 0);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(rfsh_sel == 1'b0, "R1 reset rfsh_sel", int'(rfsh_sel), 0);

        // R2 / R5: short auto-refresh (row 0 expected, R1)
        sb.push_back(next_ref());
        oe_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy at start", int'(busy), 1);
        check(row_act == 1'b1, "R2 strobe at start", int'(row_act), 1);
        @(negedge clk);
        oe_n = 1'b1;
        n = 1;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == RC + RV, "R5 busy length", n, RC + RV);
        @(negedge clk);

        // R9: access while idle; R4: pin low while selected
        ext_row = 9'h1A5;
        e.sel = 1'b0; e.row = 9'h1A5;
        sb.push_back(e);
        en0_n = 1'b0;
        @(negedge clk);
        check(row_act == 1'b1, "R9 access strobe", int'(row_act), 1);
        check(rfsh_sel == 1'b0 && busy == 1'b0, "R9 access sel/busy",
              int'({rfsh_sel, busy}), 0);
        ext_row = 9'h033;
        oe_n = 1'b0;
        repeat (4) @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
        en0_n = 1'b1;
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R4 no refresh while selected", int'(busy), 0);
        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        auto_pulse(2); // expects row 1: counter untouched by R4 stimulus

        // R10: access arriving during refresh
        sb.push_back(next_ref());
        e.sel = 1'b0; e.row = 9'h0F0;
        sb.push_back(e);
        oe_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b1;
        ext_row = 9'h0F0;
        en1_n = 1'b0;
        n = 0;
        @(negedge clk);
        while (!(row_act && !rfsh_sel) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(busy == 1'b0, "R10 access after busy", int'(busy), 0);
        check(n >= RC + RV - 1, "R10 hold-off cycles", n, RC + RV - 1);
        @(negedge clk);
        en1_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: long-ish low below self entry
        s0 = strobes;
        sb.push_back(next_ref());
        oe_n = 1'b0;
        repeat (SE - 600) @(negedge clk);
        oe_n = 1'b1;
        wait_idle();
        repeat (5) @(negedge clk);
        check(strobes - s0 == 1, "R6 single strobe", strobes - s0, 1);

        // R7 / R8: self-refresh
        s0 = strobes;
        for (int k = 0; k < 4; k++) sb.push_back(next_ref());
        oe_n = 1'b0;
        repeat (SE - 1 + SI - RC + 2 * SI + SI / 2) @(negedge clk);
        check(strobes - s0 == 4, "R7 self strobe count", strobes - s0, 4);
        t0 = stamps.size();
        if (t0 >= 3) begin
            check(stamps[t0-1] - stamps[t0-2] == SI, "R7 self spacing",
                  stamps[t0-1] - stamps[t0-2], SI);
            check(stamps[t0-2] - stamps[t0-3] == SI, "R7 self spacing",
                  stamps[t0-2] - stamps[t0-3], SI);
        end
        oe_n = 1'b1;
        n = 0;
        @(negedge clk);
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == RV, "R8 self exit recovery", n, RV);
        @(negedge clk);

        // R3: run the counter through its wrap
        for (int k = 0; k < ROWS + 4; k++) auto_pulse(2);
        check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule